// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a virtual address into a physical address by walking a three-level radix page table held in memory. A translation lookaside buffer that has missed hands it a virtual address. The walker then reads at most three 8-byte table entries, one after the other. It returns the 32-bit physical page number, the full 45-bit physical address, and a flag that tells a good translation apart from a fault.

The pages are 8 KB, so the low 13 bits of the virtual address pass through as the page offset. Above the offset sit three 10-bit index fields. The top field selects the entry in the first-level table, whose base address comes from the root input `tbl_root`. Every valid entry holds the next page number in its upper 32 bits. That number, shifted left by 13, is the base of the next table. After the third level the same number is the translation. Bit 0 of every entry is its valid bit. The walker handles one walk at a time.

All three data paths are valid/ready streams, and each one transfers on a cycle where both valid and ready are high:
- **Request port.** `req_ready` stays low while a walk is in progress.
- **Memory read port.** `mem_req_valid` and `mem_req_addr` hold steady under back-pressure. Only one read is outstanding at a time.
- **Response port.** The response fields hold steady until `rsp_ready` is high.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is high. A request is taken on a cycle with `req_valid && req_ready`. From the next cycle, `req_ready` stays low until the response handshake completes, and it is high again in the cycle after that handshake.
- R2: The first read of a walk goes to address `tbl_root + (vaddr[42:33] << 3)`.
- R3: The second read goes to `(P1 << 13) + (vaddr[32:23] << 3)`, and the third read goes to `(P2 << 13) + (vaddr[22:13] << 3)`. Here P1 and P2 are the page numbers in the first-level and second-level entries.
- R4: An entry is valid when bit 0 is 1. Its page number is bits 63:32.
- R5: If the entry read at any level is invalid, the walk ends with `rsp_fault = 1`, `rsp_ppn = 0` and `rsp_paddr = 0`, and no further memory read is issued.
- R6: A walk whose three entries are all valid returns `rsp_fault = 0`, with `rsp_ppn` set to the third-level page number and `rsp_paddr = {rsp_ppn, vaddr[12:0]}`.
- R7: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address hold steady. No new read is requested until the pending read's data has been taken with `mem_rsp_valid && mem_rsp_ready`.
- R8: While `rsp_valid` is high and `rsp_ready` is low, the response and all of its fields hold steady.
- R9: During reset `req_ready = 1`, `mem_req_valid = 0`, `rsp_valid = 0` and `mem_rsp_ready = 0`.
- R10: Virtual address bits above bit 42 have no effect on the translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | VA_W (64) | Virtual address to translate |
| tbl_root | input | 45 | Byte address of the first-level table |
| rsp_valid | output | 1 | Walk finished, response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_fault | output | 1 | Walk hit an invalid entry |
| rsp_ppn | output | 32 | Physical page number |
| rsp_paddr | output | 45 | Physical address |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 45 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Walker waits for read data |
| mem_rsp_data | input | 64 | Entry contents |

## Verification
The hardest cases to reach are stalls that arrive while a walk is in its middle levels. Examples are a read request held off for several cycles after a second-level entry has already redirected the base, or a response left pending while a new request waits at the port.

The bench builds the tables itself, choosing which level, if any, carries an invalid entry. It runs directed walks with faults at each level and with extreme index values. It then runs random walks under random read back-pressure, random memory latency and random response back-pressure. A behavioural model predicts every read address and every response, and these predictions are compared with the ports on every cycle.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int OFS_W   = 13;
  localparam int IDX_W   = 10;
  localparam int LEVELS  = 3;
  localparam int PPN_W   = 32;
  localparam int PTE_W   = 64;
  localparam int PTE_SH  = 3;
  localparam int PA_W    = PPN_W + OFS_W;
  localparam int VA_USED = OFS_W + LEVELS * IDX_W;
  localparam int LVL_W   = $clog2(LEVELS);

  typedef enum logic [2:0] {
    W_IDLE, W_L1, W_L2, W_L3, W_DONE
  } walk_st_e;
endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr
  import pt_walker_pkg::*;
(
  input  logic [VA_USED-1:0] vaddr,
  input  logic [LVL_W-1:0]   lvl,
  input  logic [PA_W-1:0]    base,
  output logic [PA_W-1:0]    addr
);
  logic [IDX_W-1:0] fld [LEVELS];
  logic [IDX_W-1:0] idx;

  for (genvar g = 0; g < LEVELS; g++) begin : g_fld
    assign fld[g] = vaddr[OFS_W + (LEVELS-1-g)*IDX_W +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int k = 0; k < LEVELS; k++)
      if (lvl == LVL_W'(k)) idx = fld[k];
  end

  assign addr = base + (PA_W'(idx) << PTE_SH);
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
  import pt_walker_pkg::*;
(
  input  logic [PTE_W-1:0] pte,
  output logic             ok,
  output logic [PPN_W-1:0] ppn,
  output logic [PA_W-1:0]  next_base
);
  logic pte_mid_unused;
  assign pte_mid_unused = ^pte[PTE_W-PPN_W-1:1];
  assign ok        = pte[0];
  assign ppn       = pte[PTE_W-1 -: PPN_W];
  assign next_base = {ppn, {OFS_W{1'b0}}};
endmodule

// File: rtl/ptw_walk_ctrl.sv
module ptw_walk_ctrl
  import pt_walker_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_USED-1:0] req_va,
  input  logic [PA_W-1:0]    root,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  input  logic               mem_rsp_valid,
  output logic               mem_rsp_ready,
  input  logic               pte_ok,
  input  logic [PPN_W-1:0]   pte_ppn,
  input  logic [PA_W-1:0]    pte_next,
  output logic [LVL_W-1:0]   lvl,
  output logic [PA_W-1:0]    base_q,
  output logic [VA_USED-1:0] va_q,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_fault,
  output logic [PPN_W-1:0]   rsp_ppn,
  output logic [PA_W-1:0]    rsp_paddr
);
  walk_st_e st;
  logic     wait_q;
  logic     busy_lvl;

  assign busy_lvl      = (st == W_L1) || (st == W_L2) || (st == W_L3);
  assign req_ready     = (st == W_IDLE);
  assign rsp_valid     = (st == W_DONE);
  assign mem_req_valid = busy_lvl && !wait_q;
  assign mem_rsp_ready = busy_lvl && wait_q;
  assign rsp_paddr     = rsp_fault ? '0 : {rsp_ppn, va_q[OFS_W-1:0]};

  always_comb begin
    case (st)
      W_L2:    lvl = LVL_W'(1);
      W_L3:    lvl = LVL_W'(2);
      default: lvl = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= W_IDLE;
      wait_q    <= 1'b0;
      base_q    <= '0;
      va_q      <= '0;
      rsp_fault <= 1'b0;
      rsp_ppn   <= '0;
    end else begin
      case (st)
        W_IDLE: if (req_valid) begin
          va_q   <= req_va;
          base_q <= root;
          wait_q <= 1'b0;
          st     <= W_L1;
        end
        W_L1, W_L2, W_L3: begin
          if (!wait_q) begin
            if (mem_req_ready) wait_q <= 1'b1;
          end else if (mem_rsp_valid) begin
            wait_q <= 1'b0;
            if (!pte_ok) begin
              rsp_fault <= 1'b1;
              rsp_ppn   <= '0;
              st        <= W_DONE;
            end else if (st == W_L3) begin
              rsp_fault <= 1'b0;
              rsp_ppn   <= pte_ppn;
              st        <= W_DONE;
            end else begin
              base_q <= pte_next;
              st     <= (st == W_L1) ? W_L2 : W_L3;
            end
          end
        end
        W_DONE: if (rsp_ready) st <= W_IDLE;
        default: st <= W_IDLE;
      endcase
    end
  end

  AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R1
  AST_ONE_READ_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R7
  AST_BAD_PTE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && mem_rsp_ready && !pte_ok) |=> (rsp_valid && rsp_fault && !mem_req_valid)); // R5
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_ppn) && $stable(rsp_fault) && $stable(rsp_paddr))); // R8
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [PA_W-1:0]   tbl_root,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fault,
  output logic [PPN_W-1:0]  rsp_ppn,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [PTE_W-1:0]  mem_rsp_data
);
  logic               va_hi_unused;
  logic               pte_ok;
  logic [PPN_W-1:0]   pte_ppn;
  logic [PA_W-1:0]    pte_next;
  logic [LVL_W-1:0]   lvl;
  logic [PA_W-1:0]    base_q;
  logic [VA_USED-1:0] va_q;

  if (VA_W > VA_USED) begin : g_hi
    assign va_hi_unused = ^req_vaddr[VA_W-1:VA_USED];
  end else begin : g_nohi
    assign va_hi_unused = 1'b0;
  end

  ptw_walk_ctrl u_ctrl (
    .clk, .rst_n,
    .req_valid, .req_ready,
    .req_va        (req_vaddr[VA_USED-1:0]),
    .root          (tbl_root),
    .mem_req_valid, .mem_req_ready,
    .mem_rsp_valid, .mem_rsp_ready,
    .pte_ok, .pte_ppn, .pte_next,
    .lvl, .base_q, .va_q,
    .rsp_valid, .rsp_ready, .rsp_fault, .rsp_ppn, .rsp_paddr
  );

  ptw_entry_addr u_addr (
    .vaddr (va_q),
    .lvl   (lvl),
    .base  (base_q),
    .addr  (mem_req_addr)
  );

  ptw_entry_decode u_dec (
    .pte       (mem_rsp_data),
    .ok        (pte_ok),
    .ppn       (pte_ppn),
    .next_base (pte_next)
  );

  AST_MEMREQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (req_ready && !mem_req_valid && !rsp_valid && !mem_rsp_ready)); // R9
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  localparam int VA_W = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [44:0] tbl_root = 45'h0_0040_0000;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_fault;
  logic [31:0] rsp_ppn;
  logic [44:0] rsp_paddr;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [44:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [63:0] mem_rsp_data = '0;

  always #4 clk = ~clk;

  pt_walker #(.VA_W(VA_W)) dut (.*);

  logic [63:0] pmem [logic [44:0]];
  logic [63:0] req_q [$];
  logic [44:0] exp_addr [$];
  int          walk_len;
  logic        exp_fault;
  logic [31:0] exp_ppn;
  logic [44:0] exp_pa;
  logic        model_busy = 1'b0;
  logic        mem_out = 1'b0;
  int          rsp_delay = 0;
  logic [44:0] pend_addr;
  logic        f_req = 0, f_mreq = 0, f_mrsp = 0, f_rsp = 0;
  logic [63:0] sav_va;
  logic        mreq_stall = 0, rsp_stall = 0;
  logic [44:0] sav_maddr;
  logic [31:0] sav_ppn;
  logic        sav_fault;
  logic [44:0] sav_pa;
  logic [44:0] last_pa;
  logic        stall_mode = 1'b0;
  int          n_chk = 0, n_fail = 0, cyc = 0;
  logic        wd = 1'b0;

  task automatic chk(input string rq, input logic ok, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [44:0] a);
    return pmem.exists(a) ? pmem[a] : 64'h0;
  endfunction

  function automatic logic [44:0] ent_addr(input logic [44:0] base, input logic [63:0] va, input int l);
    return base + (45'((va >> (33 - 10*l)) & 64'h3FF) << 3);
  endfunction

  function automatic void plan_walk(input logic [63:0] va);
    logic [44:0] base = tbl_root;
    exp_addr.delete();
    exp_fault = 1'b0;
    exp_ppn = '0;
    exp_pa = '0;
    for (int l = 0; l < 3; l++) begin
      logic [44:0] a = ent_addr(base, va, l);
      logic [63:0] pte = rd(a);
      exp_addr.push_back(a);
      if (!pte[0]) begin
        exp_fault = 1'b1;
        exp_ppn = '0;
        walk_len = exp_addr.size();
        return;
      end
      base = {pte[63:32], 13'b0};
      exp_ppn = pte[63:32];
    end
    exp_pa = {exp_ppn, va[12:0]};
    walk_len = exp_addr.size();
  endfunction

  task automatic fill(input logic [63:0] va, input int bad);
    logic [44:0] base = tbl_root;
    for (int l = 0; l < 3; l++) begin
      logic [44:0] a = ent_addr(base, va, l);
      logic [63:0] pte;
      if (l == bad) pte = {$urandom(), $urandom() & 32'hFFFF_FFFE};
      else if (pmem.exists(a) && pmem[a][0]) pte = pmem[a];
      else pte = {$urandom(), 32'h1};
      pmem[a] = pte;
      if (!pte[0]) return;
      base = {pte[63:32], 13'b0};
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (cyc > 150000) wd = 1'b1;
    if (f_rsp) begin
      model_busy = 1'b0;
      last_pa = sav_pa;
    end
    if (f_req) begin
      model_busy = 1'b1;
      plan_walk(sav_va);
      void'(req_q.pop_front());
    end
    if (f_mrsp) begin
      mem_out = 1'b0;
      mem_rsp_valid = 1'b0;
    end
    if (f_mreq) begin
      mem_out = 1'b1;
      pend_addr = sav_maddr;
      rsp_delay = stall_mode ? $urandom_range(0, 3) : 0;
      if (exp_addr.size() > 0) void'(exp_addr.pop_front());
    end
    // checks against the model
    chk("R1 req_ready", req_ready == !model_busy, 64'(req_ready), 64'(!model_busy));
    if (mreq_stall) begin
      chk("R7 held valid", mem_req_valid, 64'(mem_req_valid), 64'd1);
      chk("R7 held addr", mem_req_addr == sav_maddr, 64'(mem_req_addr), 64'(sav_maddr));
    end
    if (mem_req_valid) begin
      chk("R7 single read", !mem_out, 64'(mem_out), 64'd0);
      chk("R5 no extra read", exp_addr.size() > 0, 64'(exp_addr.size()), 64'd1);
      if (exp_addr.size() > 0) begin
        if (walk_len - exp_addr.size() == 0)
          chk("R2 L1 addr", mem_req_addr == exp_addr[0], 64'(mem_req_addr), 64'(exp_addr[0]));
        else
          chk("R3 L2/L3 addr", mem_req_addr == exp_addr[0], 64'(mem_req_addr), 64'(exp_addr[0]));
      end
    end
    if (rsp_stall) begin
      chk("R8 held rsp", rsp_valid && rsp_ppn == sav_ppn && rsp_fault == sav_fault && rsp_paddr == sav_pa,
          {rsp_ppn, 31'(rsp_paddr), rsp_fault}, {sav_ppn, 31'(sav_pa), sav_fault});
    end
    if (rsp_valid) begin
      chk("R5 reads done", exp_addr.size() == 0 && !mem_out, 64'(exp_addr.size()), 64'd0);
      chk("R5 fault flag", rsp_fault == exp_fault, 64'(rsp_fault), 64'(exp_fault));
      chk("R4 ppn", rsp_ppn == exp_ppn, 64'(rsp_ppn), 64'(exp_ppn));
      chk("R6 paddr", rsp_paddr == exp_pa, 64'(rsp_paddr), 64'(exp_pa));
    end
    // drive inputs
    req_valid = (req_q.size() > 0);
    req_vaddr = (req_q.size() > 0) ? req_q[0] : 64'h0;
    mem_req_ready = stall_mode ? 1'($urandom_range(0, 1)) : 1'b1;
    rsp_ready = stall_mode ? 1'($urandom_range(0, 1)) : 1'b1;
    if (mem_out && !mem_rsp_valid) begin
      if (rsp_delay == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data = rd(pend_addr);
      end else rsp_delay--;
    end
    // handshakes at the coming edge
    f_req  = req_valid && req_ready;
    sav_va = req_vaddr;
    f_mreq = mem_req_valid && mem_req_ready;
    sav_maddr = mem_req_addr;
    f_mrsp = mem_rsp_valid && mem_rsp_ready;
    f_rsp  = rsp_valid && rsp_ready;
    mreq_stall = mem_req_valid && !mem_req_ready;
    rsp_stall  = rsp_valid && !rsp_ready;
    sav_ppn = rsp_ppn;
    sav_fault = rsp_fault;
    sav_pa = rsp_paddr;
  endtask

  task automatic run_walk(input logic [63:0] va);
    int n = 0;
    req_q.push_back(va);
    while ((req_q.size() > 0 || model_busy || f_req) && !wd && n < 3000) begin
      step();
      n++;
    end
    if (n >= 3000 || wd) begin
      wd = 1'b1;
      chk("R1 watchdog", 1'b0, 64'(n), 64'd0);
    end
  endtask

  initial begin
    logic [63:0] va_a, pa_keep;
    @(negedge clk);
    chk("R9 req_ready", req_ready, 64'(req_ready), 64'd1);
    chk("R9 mem_req_valid", !mem_req_valid, 64'(mem_req_valid), 64'd0);
    chk("R9 rsp_valid", !rsp_valid, 64'(rsp_valid), 64'd0);
    chk("R9 mem_rsp_ready", !mem_rsp_ready, 64'(mem_rsp_ready), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    va_a = {21'h0, 10'd3, 10'd5, 10'd7, 13'h123};
    fill(va_a, 3);
    run_walk(va_a);
    pa_keep = 64'(last_pa);
    run_walk(va_a | {21'h1F_FFFF, 43'h0});
    chk("R10 upper bits", 64'(last_pa) == pa_keep, 64'(last_pa), pa_keep);

    for (int b = 0; b < 3; b++) begin
      logic [63:0] v = {21'h0, 10'(100 + b), 10'(200 + b), 10'(300 + b), 13'h1F0};
      fill(v, b);
      run_walk(v);
    end
    fill({21'h0, 10'h3FF, 10'h3FF, 10'h3FF, 13'h1FFF}, 3);
    run_walk({21'h0, 10'h3FF, 10'h3FF, 10'h3FF, 13'h1FFF});
    fill({21'h0, 10'h0, 10'h0, 10'h0, 13'h0}, 3);
    run_walk({21'h0, 10'h0, 10'h0, 10'h0, 13'h0});

    stall_mode = 1'b1;
    for (int i = 0; i < 80 && !wd; i++) begin
      logic [63:0] v = {$urandom(), $urandom()};
      int bad = $urandom_range(0, 5);
      fill(v, bad);
      run_walk(v);
    end
    // back-to-back requests queued while busy
    for (int i = 0; i < 6 && !wd; i++) begin
      logic [63:0] v = {32'h0, $urandom()} << 11;
      fill(v, 3);
      req_q.push_back(v);
    end
    run_walk({21'h0, 10'd3, 10'd5, 10'd7, 13'h0});
    repeat (4) step();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule